// File: doc/BRIEF.md
# Tiled View Address Generator

This block turns a pixel coordinate into an address inside a two-dimensional tiled container. A caller presents a format code (the element size: 8, 16 or 32 bits), a 3-bit orientation code, and X and Y pixel coordinates. The block returns the container address of that pixel and the line stride for the chosen format and orientation. It also returns a flag that marks an unusable coordinate or format.

The orientation code carries three controls: mirror X, mirror Y and swap the axes. Mirroring is applied to the coordinate first. The possibly swapped pair is then packed into a single index. That index is shifted left by an alignment that depends on the format. The format code and the orientation code go into the top five address bits, so that the memory system behind the container can select the matching view.

The datapath is combinational. By default a result register follows it, loaded by an input strobe, so each result appears one cycle after its request.

Top module: `tiled_addr_gen`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high. A result appears one clock after its request.
- R2: For a valid request, address bits [28:27] hold the format code: 0 for 8-bit, 1 for 16-bit and 2 for 32-bit elements.
- R3: For a valid request, address bits [31:29] hold the orientation code unchanged.
- R4: Each format drops some coordinate bits (X shift xs, Y shift ys): (0,0) for 8-bit, (0,1) for 16-bit and (1,1) for 32-bit. The X range is XBITS−xs bits and the Y range is YBITS−ys bits. If either coordinate exceeds its mask, `bad_coord` is 1 and the address is 0.
- R5: Format code 3 is invalid. It gives `bad_coord`=1, address 0 and stride 0.
- R6: Orientation bit 0 replaces x with (X mask − x). Orientation bit 1 replaces y with (Y mask − y). Both are applied before any swap.
- R7: With orientation bit 2 clear, the packed index is (y << X width) + x. With bit 2 set, it is (x << Y width) + y.
- R8: The packed index is shifted left by xs+ys and occupies address bits [26:0].
- R9: The stride is 2^(YBITS+xs) when bit 2 is set, and 2^(XBITS+ys) otherwise. With the defaults XBITS=14 and YBITS=13 this gives 16384/8192 (8-bit), 32768/8192 (16-bit) and 32768/16384 (32-bit), listed as unswapped/swapped.
- R10: After reset all outputs are 0. Outputs hold their last values while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| fmt | input | 2 | Element-size format code |
| orient | input | 3 | Orientation: bit0 X mirror, bit1 Y mirror, bit2 axis swap |
| x_in | input | XBITS | Pixel X coordinate |
| y_in | input | YBITS | Pixel Y coordinate |
| out_valid | output | 1 | Result valid |
| addr | output | 32 | Tiled container address |
| stride | output | 32 | Line stride in bytes |
| bad_coord | output | 1 | Coordinate out of range or format invalid |

## Verification
The bench aims at the edges of each format's coordinate range. It drives the largest legal X and Y and the first values past them. A design that used the full container width for every format would accept an out-of-range 32-bit X, or would produce an address whose index runs into the format bits.

Mirror and swap are driven together, on all eight orientations. A design that swapped before mirroring would pick the wrong mask for each axis and would misplace non-square coordinates.

Format code 3 and idle cycles between requests are also covered. These catch a stride left nonzero on an invalid format, and outputs that drift while no request is present.

// File: rtl/tiled_addr_gen.sv
module tiled_addr_gen #(
  parameter int XBITS   = 14,
  parameter int YBITS   = 13,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       fmt,
  input  logic [2:0]       orient,
  input  logic [XBITS-1:0] x_in,
  input  logic [YBITS-1:0] y_in,
  output logic             out_valid,
  output logic [31:0]      addr,
  output logic [31:0]      stride,
  output logic             bad_coord
);
  localparam int IDXW = 27;
  localparam logic [31:0] XFULL = (32'd1 << XBITS) - 32'd1;
  localparam logic [31:0] YFULL = (32'd1 << YBITS) - 32'd1;

  logic        xs, ys, fmt_bad, rng_bad, bad_c;
  logic [5:0]  xw, yw;
  logic [31:0] xmask, ymask, xv, yv, xe, ye, packed_idx, aligned, addr_c, stride_c;

  assign xs      = (fmt == 2'd2);
  assign ys      = (fmt == 2'd1) || (fmt == 2'd2);
  assign fmt_bad = (fmt == 2'd3);
  assign xw      = 6'(XBITS) - {5'd0, xs};
  assign yw      = 6'(YBITS) - {5'd0, ys};
  assign xmask   = XFULL >> xs;
  assign ymask   = YFULL >> ys;
  assign xv      = 32'(x_in);
  assign yv      = 32'(y_in);
  assign rng_bad = (xv > xmask) || (yv > ymask);
  assign bad_c   = fmt_bad || rng_bad;

  assign xe = orient[0] ? (xmask - xv) : xv;
  assign ye = orient[1] ? (ymask - yv) : yv;

  assign packed_idx = orient[2] ? ((xe << yw) + ye) : ((ye << xw) + xe);
  assign aligned    = packed_idx << ({1'b0, xs} + {1'b0, ys});

  assign addr_c   = bad_c ? 32'd0 : {orient, fmt, aligned[IDXW-1:0]};
  assign stride_c = fmt_bad ? 32'd0 :
                    orient[2] ? (32'd1 << (YBITS + int'(xs))) :
                                (32'd1 << (XBITS + int'(ys)));

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          addr      <= '0;
          stride    <= '0;
          bad_coord <= 1'b0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) begin
            addr      <= addr_c;
            stride    <= stride_c;
            bad_coord <= bad_c;
          end
        end
      end
    end else begin : g_comb
      assign out_valid = in_valid;
      assign addr      = addr_c;
      assign stride    = stride_c;
      assign bad_coord = bad_c;
    end
  endgenerate
endmodule

module tiled_addr_gen_chk #(
  parameter int XBITS = 14,
  parameter int YBITS = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       fmt,
  input logic [2:0]       orient,
  input logic [XBITS-1:0] x_in,
  input logic [YBITS-1:0] y_in,
  input logic             out_valid,
  input logic [31:0]      addr,
  input logic [31:0]      stride,
  input logic             bad_coord
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_fmt_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (bad_coord || addr[28:27] == $past(fmt)));
  assert_view_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (bad_coord || addr[31:29] == $past(orient)));
  assert_bad_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && bad_coord) |-> (addr == 32'd0));
  assert_fmt3_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt == 2'd3) |=> (bad_coord && stride == 32'd0));
  assert_stride_pow2_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt != 2'd3) |=> ($countones(stride) == 1));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(addr) && $stable(stride) && $stable(bad_coord)));
endmodule

bind tiled_addr_gen tiled_addr_gen_chk #(.XBITS(XBITS), .YBITS(YBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt(fmt), .orient(orient),
  .x_in(x_in), .y_in(y_in), .out_valid(out_valid), .addr(addr),
  .stride(stride), .bad_coord(bad_coord)
);

// File: tb/sim_tiled_addr_gen.sv
module sim_tiled_addr_gen;
  localparam int XB = 14;
  localparam int YB = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] fmt = '0;
  logic [2:0] orient = '0;
  logic [XB-1:0] x_in = '0;
  logic [YB-1:0] y_in = '0;
  logic out_valid, bad_coord;
  logic [31:0] addr, stride;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [64:0] exp_q[$];
  string       tag_q[$];
  logic [64:0] last_res;
  bit          have_last = 1'b0;

  always #5 clk = ~clk;

  tiled_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt(fmt), .orient(orient),
    .x_in(x_in), .y_in(y_in), .out_valid(out_valid), .addr(addr),
    .stride(stride), .bad_coord(bad_coord)
  );

  function automatic logic [64:0] model(input int f, input int o, input int x, input int y);
    int sx, sy, xw, yw, xm, ym, xe, ye, idx;
    logic [31:0] a, s;
    if (f == 3) return {1'b1, 32'd0, 32'd0};
    sx = (f == 2) ? 1 : 0;
    sy = (f == 0) ? 0 : 1;
    xw = XB - sx;
    yw = YB - sy;
    xm = (1 << xw) - 1;
    ym = (1 << yw) - 1;
    s = ((o & 4) != 0) ? (32'd1 << (YB + sx)) : (32'd1 << (XB + sy));
    if (x > xm || y > ym) return {1'b1, 32'd0, s};
    xe = ((o & 1) != 0) ? xm - x : x;
    ye = ((o & 2) != 0) ? ym - y : y;
    idx = ((o & 4) != 0) ? (xe * (1 << yw) + ye) : (ye * (1 << xw) + xe);
    idx = idx << (sx + sy);
    a = {3'(o), 2'(f), 27'(idx)};
    return {1'b0, a, s};
  endfunction

  task automatic check(input string tag, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s bad=%0b addr=%h stride=%h expected bad=%0b addr=%h stride=%h",
               tag, act[64], act[63:32], act[31:0], exp[64], exp[63:32], exp[31:0]);
    end
  endtask

  task automatic drive(input int f, input int o, input int x, input int y, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    fmt = 2'(f);
    orient = 3'(o);
    x_in = XB'(x);
    y_in = YB'(y);
    exp_q.push_back(model(f, o, x, y));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      x_in = '1;
      y_in = '0;
      fmt = 2'd3;
    end
  endtask

  // monitor / scoreboard
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R1 unexpected out_valid actual=1 expected=0");
        end else begin
          last_res = exp_q.pop_front();
          check(tag_q.pop_front(), {bad_coord, addr, stride}, last_res);
          have_last = 1'b1;
        end
      end else if (have_last) begin
        check("R10 hold while idle", {bad_coord, addr, stride}, last_res);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset state", {bad_coord, addr, stride}, 65'd0);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset out_valid actual=%0b expected=0", out_valid);
    end
    rst_n = 1'b1;

    // hand-worked points
    drive(0, 0, 5, 3, "R7 R2 R3 fmt0 plain");
    idle(1);
    checks++;
    if (addr !== 32'h0000C005) begin
      errors++;
      $display("FAIL R7 literal actual=%h expected=0000c005", addr);
    end
    drive(2, 4, 1, 2, "R8 R9 fmt2 swap");
    drive(1, 0, 0, 4095, "R4 R8 fmt1 y at mask");
    drive(1, 0, 0, 4096, "R4 fmt1 y past mask");
    drive(2, 0, 8191, 0, "R4 fmt2 x at mask");
    drive(2, 0, 8192, 0, "R4 fmt2 x past mask");
    drive(0, 0, 16383, 8191, "R4 fmt0 corner");
    drive(3, 0, 1, 1, "R5 fmt3 invalid");
    drive(3, 5, 0, 0, "R5 fmt3 invalid swapped");
    idle(3);

    // all formats and orientations at asymmetric coordinates
    for (int f = 0; f < 3; f++)
      for (int o = 0; o < 8; o++) begin
        drive(f, o, 37 + f, 1001 - 5 * o, "R6 R7 R9 orient sweep");
        drive(f, o, 0, 0, "R6 R3 origin mirror");
      end
    idle(2);

    for (int i = 0; i < 300; i++) begin
      int f = $urandom_range(0, 3);
      int o = $urandom_range(0, 7);
      int x = $urandom_range(0, 16383);
      int y = $urandom_range(0, 8191);
      drive(f, o, x, y, "R2 R4 R6 R7 R8 mixed");
      if ((i % 17) == 0) idle(2);
    end
    idle(4);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1 missing results actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule